// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block gathers asynchronous event lines from the analog and clocking parts of a converter, such as a lost-lock indication from the clock synthesizer and an over-range flag from the record path. It records each event as a sticky status bit and raises a single interrupt line toward a host. Each raw event line first passes through a two-flop synchronizer. A rising edge on a line whose enable bit is set then latches the matching status bit. The host clears the bits by reading the status word. The read is modelled here as a one-cycle strobe and stands in for the real register access protocol.

The enable word uses positive logic: a 1 lets its source into the status word and onto the interrupt line. After reset the word is zero, so every source is blocked. The interrupt is the OR of all latched bits whose enable is set. It drives an output pin in one of three styles: active low, active high, or active low open-drain. In the open-drain style the output-enable is asserted only while the line must be pulled low.

Top module: `irq_status_ctrl`

## Requirements
- R1: While and after reset, every status bit is 0 and the interrupt is inactive.
- R2: A 0-to-1 change on an enabled event line sets its status bit at the third rising clock edge after the change is applied. This is two synchronizer stages plus the edge-detect stage.
- R3: A rising edge on an event line whose enable bit is 0 does not set its status bit.
- R4: An event line held high sets its bit only once. A read taken while the synchronized line is still high and enabled leaves the bit set.
- R5: A read strobe clears every status bit whose synchronized source is low or disabled at that clock edge.
- R6: Without a read strobe, a set status bit stays set.
- R7: The interrupt is active exactly when some status bit and its enable bit are both 1. Clearing an enable bit hides its latched bit from the pin but does not clear the bit.
- R8: Pin mode 0 (active low): the pin data is the inverse of the interrupt and the output-enable is 1.
- R9: Pin mode 1 (active high): the pin data equals the interrupt and the output-enable is 1.
- R10: Pin mode 2 (open-drain): the pin data is always 0 and the output-enable equals the interrupt.
- R11: Pin mode 3 behaves as pin mode 0.
- R12: Status and enable bit 0 belong to the clock-lock-lost event and bit 1 to the converter over-range event. Each bit index follows its event input index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_raw | input | NUM_SRC | Asynchronous event lines, bit 0 lock lost, bit 1 over-range |
| src_en | input | NUM_SRC | Per-source enable, 1 admits the source |
| pin_mode | input | 2 | Output style: 0 active low, 1 active high, 2 open-drain, 3 as 0 |
| stat_rd | input | 1 | One-cycle status read strobe, clears on the edge |
| status | output | NUM_SRC | Latched status bits |
| irq_pin_o | output | 1 | Interrupt pin data |
| irq_pin_oe | output | 1 | Interrupt pin output-enable |

## Verification
Single-cycle pulses and long levels on each event line separate edge capture from level capture. A read issued while a line is still high shows whether the bit is set again. Pulses on a disabled line, and enable changes after a bit is latched, separate gating at the status word from gating at the pin. The same latched state is then shown in all four pin modes, which separates polarity from drive style. A behavioural reference model is compared with every output on every cycle, so the exact three-edge latency is checked as well as the final values.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
   typedef enum logic [1:0] {
      PIN_ACT_LO     = 2'd0,
      PIN_ACT_HI     = 2'd1,
      PIN_OPEN_DRAIN = 2'd2,
      PIN_RSVD       = 2'd3
   } pin_mode_e;

   localparam int SRC_LOCK_LOST = 0;
   localparam int SRC_OVER_RNG  = 1;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   logic [STAGES-1:0][WIDTH-1:0] chain;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain[0] <= '0;
               else        chain[0] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
   parameter int WIDTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl,
   input  logic [WIDTH-1:0] src_en,
   input  logic             rd,
   output logic [WIDTH-1:0] stat_q
);
   logic [WIDTH-1:0] lvl_prev;
   logic [WIDTH-1:0] rise;
   logic [WIDTH-1:0] keep;
   logic [WIDTH-1:0] set_now;

   assign rise    = lvl & ~lvl_prev;
   assign keep    = rd ? '0 : stat_q;
   assign set_now = src_en & (rise | (rd ? lvl : '0));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_prev <= '0;
         stat_q   <= '0;
      end else begin
         lvl_prev <= lvl;
         stat_q   <= keep | set_now;
      end
   end
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv
   import irq_ctrl_pkg::*;
(
   input  logic       irq_act,
   input  logic [1:0] mode,
   output logic       pin_o,
   output logic       pin_oe
);
   pin_mode_e m;
   assign m = pin_mode_e'(mode);

   always_comb begin
      unique case (m)
         PIN_ACT_HI: begin
            pin_o  = irq_act;
            pin_oe = 1'b1;
         end
         PIN_OPEN_DRAIN: begin
            pin_o  = 1'b0;
            pin_oe = irq_act;
         end
         default: begin
            pin_o  = ~irq_act;
            pin_oe = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
   parameter int NUM_SRC     = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt_raw,
   input  logic [NUM_SRC-1:0] src_en,
   input  logic [1:0]         pin_mode,
   input  logic               stat_rd,
   output logic [NUM_SRC-1:0] status,
   output logic               irq_pin_o,
   output logic               irq_pin_oe
);
   generate
      if (NUM_SRC < 1 || NUM_SRC > 32) begin : g_bad_src
         $error("irq_status_ctrl: NUM_SRC out of range");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("irq_status_ctrl: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [NUM_SRC-1:0] evt_lvl;
   logic               irq_act;

   irq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (evt_raw),
      .q_sync  (evt_lvl)
   );

   irq_status_bank #(.WIDTH(NUM_SRC)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl    (evt_lvl),
      .src_en (src_en),
      .rd     (stat_rd),
      .stat_q (status)
   );

   assign irq_act = |(status & src_en);

   irq_pin_drv u_pin (
      .irq_act (irq_act),
      .mode    (pin_mode),
      .pin_o   (irq_pin_o),
      .pin_oe  (irq_pin_oe)
   );
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk #(
   parameter int NUM_SRC = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] src_en,
   input logic [1:0]         pin_mode,
   input logic               stat_rd,
   input logic [NUM_SRC-1:0] status,
   input logic               irq_pin_o,
   input logic               irq_pin_oe
);
   // R3: a bit can only come up if its source was enabled at that edge
   assert_masked_no_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((status & ~$past(status) & ~$past(src_en)) == '0));

   // R6: no bit falls without a read strobe
   assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(stat_rd) |-> (($past(status) & ~status) == '0));

   // R5: a read with every source disabled leaves an empty word
   assert_read_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(stat_rd) && ($past(src_en) == '0)) |-> (status == '0));

   // R10: open-drain never drives high
   assert_od_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_mode == 2'd2) |-> (irq_pin_o == 1'b0 && irq_pin_oe == (|(status & src_en))));

   // R8 R9 R11: push-pull styles always drive
   assert_pp_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_mode != 2'd2) |-> irq_pin_oe);

   // R7 R9: active-high pin follows enabled latched bits
   assert_hi_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_mode == 2'd1) |-> (irq_pin_o == (|(status & src_en))));
endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .src_en     (src_en),
   .pin_mode   (pin_mode),
   .stat_rd    (stat_rd),
   .status     (status),
   .irq_pin_o  (irq_pin_o),
   .irq_pin_oe (irq_pin_oe)
);

// File: tb/irq_status_ctrl_tb.sv
module irq_status_ctrl_tb;
   localparam int N = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] evt_raw = '0;
   logic [N-1:0] src_en = '0;
   logic [1:0]   pin_mode = 2'd0;
   logic         stat_rd = 1'b0;
   logic [N-1:0] status;
   logic         irq_pin_o;
   logic         irq_pin_oe;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   irq_status_ctrl #(.NUM_SRC(N)) u_dut (
      .clk(clk), .rst_n(rst_n), .evt_raw(evt_raw), .src_en(src_en),
      .pin_mode(pin_mode), .stat_rd(stat_rd), .status(status),
      .irq_pin_o(irq_pin_o), .irq_pin_oe(irq_pin_oe)
   );

   // reference model: two sync stages, edge detect, sticky word
   logic [N-1:0] m_s1 = '0, m_s2 = '0, m_prev = '0, m_stat = '0;
   always @(posedge clk) begin
      logic [N-1:0] nx;
      if (!rst_n) begin
         m_s1 = '0; m_s2 = '0; m_prev = '0; m_stat = '0;
      end else begin
         nx = stat_rd ? '0 : m_stat;
         nx = nx | (src_en & m_s2 & ~m_prev);
         if (stat_rd) nx = nx | (src_en & m_s2);
         m_prev = m_s2; m_s2 = m_s1; m_s1 = evt_raw; m_stat = nx;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) if (rst_n && !done) begin
      logic a; logic eo; logic eoe; string t;
      a = |(m_stat & src_en);
      case (pin_mode)
         2'd1: begin eo = a;    eoe = 1'b1; t = "R9";  end
         2'd2: begin eo = 1'b0; eoe = a;    t = "R10"; end
         2'd3: begin eo = ~a;   eoe = 1'b1; t = "R11"; end
         default: begin eo = ~a; eoe = 1'b1; t = "R8"; end
      endcase
      chk(status == m_stat, "R2 status vs model", status, m_stat);
      chk({irq_pin_o, irq_pin_oe} == {eo, eoe}, t, {irq_pin_o, irq_pin_oe}, {eo, eoe});
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input int idx);
      evt_raw[idx] = 1'b1; cyc(1); evt_raw[idx] = 1'b0;
   endtask

   task automatic rd();
      stat_rd = 1'b1; cyc(1); stat_rd = 1'b0;
   endtask

   initial begin
      cyc(3);
      chk(status == '0 && irq_pin_o && irq_pin_oe, "R1 reset", {status, irq_pin_o, irq_pin_oe}, 3'b011);
      rst_n = 1'b1;
      cyc(1);
      chk(status == '0, "R1 after reset", status, 0);
      src_en = 2'b11;
      // R2 latency, R12 bit 0
      evt_raw[0] = 1'b1;
      cyc(2);
      chk(status[0] == 1'b0, "R2 not before third edge", status, 0);
      cyc(1);
      chk(status == 2'b01, "R2 R12 bit0 set on third edge", status, 1);
      // R4: held level, read re-sets
      cyc(3);
      rd();
      chk(status == 2'b01, "R4 read while high keeps bit", status, 1);
      evt_raw[0] = 1'b0;
      cyc(4);
      chk(status == 2'b01, "R6 sticky without read", status, 1);
      rd();
      chk(status == 2'b00, "R5 read clears low source", status, 0);
      // R4 level alone does not re-set after being cleared
      evt_raw[0] = 1'b1; cyc(4); rd(); evt_raw[0] = 1'b0; cyc(3); rd();
      chk(status == 2'b00, "R4 level does not re-latch", status, 0);
      // R3 masked pulse
      src_en = 2'b10;
      pulse(0); cyc(5);
      chk(status == 2'b00, "R3 disabled source ignored", status, 0);
      chk(irq_pin_o == 1'b1, "R3 pin inactive", irq_pin_o, 1);
      // R12 bit 1
      pulse(1); cyc(4);
      chk(status == 2'b10, "R12 bit1 over-range", status, 2);
      // R7 enable hides bit but keeps it
      src_en = 2'b00; cyc(1);
      chk(irq_pin_o == 1'b1 && status == 2'b10, "R7 hidden not cleared", {status, irq_pin_o}, 3'b101);
      src_en = 2'b10; cyc(1);
      chk(irq_pin_o == 1'b0, "R7 R8 active low asserted", irq_pin_o, 0);
      pin_mode = 2'd1; cyc(1);
      chk(irq_pin_o == 1'b1, "R9 active high", irq_pin_o, 1);
      pin_mode = 2'd2; cyc(1);
      chk(irq_pin_o == 1'b0 && irq_pin_oe == 1'b1, "R10 open-drain pull", {irq_pin_o, irq_pin_oe}, 1);
      pin_mode = 2'd3; cyc(1);
      chk(irq_pin_o == 1'b0 && irq_pin_oe == 1'b1, "R11 mode3 as active low", {irq_pin_o, irq_pin_oe}, 1);
      pin_mode = 2'd2; rd();
      chk(irq_pin_oe == 1'b0 && status == 2'b00, "R10 open-drain released", {status, irq_pin_oe}, 0);
      // both sources together
      src_en = 2'b11; pin_mode = 2'd0;
      evt_raw = 2'b11; cyc(1); evt_raw = 2'b00; cyc(4);
      chk(status == 2'b11, "R2 both sources", status, 3);
      rd(); cyc(2);
      chk(status == 2'b00, "R5 both cleared", status, 0);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule